// File: doc/BRIEF.md
# Atomic Read-Modify-Write Bridge

This block sits between one bus requester and a memory bus that knows only plain reads and writes. It carries out atomic memory operations on the requester's behalf. When an upstream request has its atomic flag set, the bridge runs a locked read of the addressed word and computes the new value from the old word and the request's operand. It then issues a locked full-word write and returns the old word upstream. Requests without the atomic flag go through to the downstream bus unchanged, and their response comes back unchanged.

The bridge also provides load-reserved and store-conditional with a single reservation register. A load-reserved reads the word and remembers its word address. A store-conditional writes only while that reservation is valid and matches its address. It answers 0 on success and 1 on failure. Only one request is in flight at a time. Strobes that arrive while an operation is outstanding are dropped.

Top module: `amo_unit`

## Requirements
- R1: With the atomic flag clear, the request goes downstream in its strobe cycle with the same address, write data, byte enables, direction and lock bit. The operation code is ignored. Read data, acknowledge and error come back to the requester unchanged.
- R2: An atomic read-modify-write first issues a read with lock high. After that read is acknowledged, it issues a write with lock high and all four byte enables set. The acknowledge returns the word as it was before the operation.
- R3: Operation codes use a 4-bit field. Code 0000 stores the operand (swap). Code 0001 adds modulo 2^32. Codes 0010/1010 give XOR, 0011/1011 give AND and 0100/1100 give OR, so bit 3 is ignored for these. Codes 0101 and 1101 store the operand.
- R4: Code 0110 stores the unsigned minimum of the old word and the operand, and 0111 the unsigned maximum. Codes 1110 and 1111 do the same with signed comparison, so 0x80000000 is the smallest value and 0x7FFFFFFF the largest.
- R5: If the read of an atomic operation ends in an error, no write is issued and the error goes upstream.
- R6: If the write of an atomic operation ends in an error, the error goes upstream instead of an acknowledge.
- R7: Load-reserved (code 1000) issues one unlocked read. It returns the data read and makes a reservation on that word address.
- R8: Store-conditional (code 1001) to the reserved word issues one unlocked full-word write of the request data and answers 0.
- R9: Store-conditional with no valid reservation, or to a different word, issues no downstream access and answers 1 in the cycle after its strobe. Every store-conditional clears the reservation.
- R10: Any write sent downstream to the reserved word clears the reservation, partial-byte plain writes included.
- R11: While a request is outstanding, new upstream strobes are ignored and cause no downstream access.
- R12: Each downstream strobe lasts one cycle. Responses may arrive any number of cycles after the strobe, and acknowledge and error are never raised together upstream.
- R13: After reset there is no downstream strobe, no upstream response and no valid reservation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| upAddr | input | 32 | Requester byte address |
| upWdata | input | 32 | Requester write data or atomic operand |
| upBen | input | 4 | Requester byte enables |
| upStb | input | 1 | Requester one-cycle request strobe |
| upRw | input | 1 | Direction, 1 = write |
| upLock | input | 1 | Lock bit of a plain request |
| upAmo | input | 1 | Atomic flag |
| upOp | input | 4 | Atomic operation code |
| upRdata | output | 32 | Response data to the requester |
| upAck | output | 1 | Response acknowledge |
| upErr | output | 1 | Response error |
| dnAddr | output | 32 | Memory bus byte address |
| dnWdata | output | 32 | Memory bus write data |
| dnBen | output | 4 | Memory bus byte enables |
| dnStb | output | 1 | Memory bus one-cycle strobe |
| dnRw | output | 1 | Memory bus direction, 1 = write |
| dnLock | output | 1 | Memory bus lock, marks an atomic pair |
| dnRdata | input | 32 | Memory bus read data |
| dnAck | input | 1 | Memory bus acknowledge |
| dnErr | input | 1 | Memory bus error |

## Verification
The bench builds the bridge with its default 32-bit address and data widths. At these widths the signed and unsigned boundary words 0x80000000, 0x7FFFFFFF and 0xFFFFFFFF separate the four comparison codes, and carry-out wraparound separates addition. The bench's memory model takes its response latency and error targets from the bench, so the same widths cover next-cycle and delayed responses, and errors on either half of a read-modify-write.

// File: rtl/amo_pkg.sv
package amo_pkg;

  localparam logic [3:0] OP_LR = 4'b1000;
  localparam logic [3:0] OP_SC = 4'b1001;

  // downstream source select
  typedef enum logic [1:0] {
    DN_UP   = 2'd0,  // raw upstream request
    DN_UPW  = 2'd1,  // upstream address word-aligned, full word
    DN_HOLD = 2'd2,  // captured word address, read
    DN_NEW  = 2'd3   // captured word address, computed value
  } dsel_e;

  // upstream read data select
  typedef enum logic [1:0] {
    UP_DN   = 2'd0,
    UP_OLD  = 2'd1,
    UP_ZERO = 2'd2,
    UP_ONE  = 2'd3
  } rsel_e;

  typedef struct packed {
    logic  capture;
    logic  loadOld;
    logic  setResv;
    logic  clrResv;
    dsel_e dnSel;
    rsel_e upSel;
  } ctl_t;

endpackage

// File: rtl/amo_datapath.sv
module amo_datapath
  import amo_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic [ADDR_W-1:0] upAddr,
  input  logic [DATA_W-1:0] upWdata,
  input  logic [DATA_W/8-1:0] upBen,
  input  logic [3:0]        upOp,
  input  logic [DATA_W-1:0] dnRdata,
  input  logic              wrIssue,
  output logic [ADDR_W-1:0] dnAddr,
  output logic [DATA_W-1:0] dnWdata,
  output logic [DATA_W/8-1:0] dnBen,
  output logic [DATA_W-1:0] upRdata,
  output logic              resvHit
);

  localparam int BEN_W = DATA_W / 8;
  localparam int OFS_W = $clog2(BEN_W);
  localparam int WA_W  = ADDR_W - OFS_W;

  logic [WA_W-1:0]   reqWord;
  logic [3:0]        reqOp;
  logic [DATA_W-1:0] reqOpd;
  logic [DATA_W-1:0] oldVal;
  logic [DATA_W-1:0] newVal;
  logic              resvValid;
  logic [WA_W-1:0]   resvWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqWord <= '0;
      reqOp   <= '0;
      reqOpd  <= '0;
      oldVal  <= '0;
    end else begin
      if (ctl.capture) begin
        reqWord <= upAddr[ADDR_W-1:OFS_W];
        reqOp   <= upOp;
        reqOpd  <= upWdata;
      end
      if (ctl.loadOld) oldVal <= dnRdata;
    end
  end

  // single reservation; set has priority, any write to the word clears it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resvValid <= 1'b0;
      resvWord  <= '0;
    end else if (ctl.setResv) begin
      resvValid <= 1'b1;
      resvWord  <= reqWord;
    end else if (ctl.clrResv || (wrIssue && dnAddr[ADDR_W-1:OFS_W] == resvWord)) begin
      resvValid <= 1'b0;
    end
  end

  assign resvHit = resvValid && (upAddr[ADDR_W-1:OFS_W] == resvWord);

  // modify stage; low three code bits choose, bit 3 picks signedness
  always_comb begin
    unique case (reqOp[2:0])
      3'b001:  newVal = oldVal + reqOpd;
      3'b010:  newVal = oldVal ^ reqOpd;
      3'b011:  newVal = oldVal & reqOpd;
      3'b100:  newVal = oldVal | reqOpd;
      3'b110:  newVal = (reqOp[3] ? ($signed(oldVal) < $signed(reqOpd)) : (oldVal < reqOpd))
                        ? oldVal : reqOpd;
      3'b111:  newVal = (reqOp[3] ? ($signed(oldVal) > $signed(reqOpd)) : (oldVal > reqOpd))
                        ? oldVal : reqOpd;
      default: newVal = reqOpd;
    endcase
  end

  always_comb begin
    dnBen   = '1;
    dnWdata = '0;
    unique case (ctl.dnSel)
      DN_UP: begin
        dnAddr  = upAddr;
        dnWdata = upWdata;
        dnBen   = upBen;
      end
      DN_UPW: begin
        dnAddr  = {upAddr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
        dnWdata = upWdata;
      end
      DN_HOLD: dnAddr = {reqWord, {OFS_W{1'b0}}};
      default: begin
        dnAddr  = {reqWord, {OFS_W{1'b0}}};
        dnWdata = newVal;
      end
    endcase
  end

  always_comb begin
    unique case (ctl.upSel)
      UP_OLD:  upRdata = oldVal;
      UP_ZERO: upRdata = '0;
      UP_ONE:  upRdata = DATA_W'(1);
      default: upRdata = dnRdata;
    endcase
  end

endmodule

// File: rtl/amo_control.sv
module amo_control
  import amo_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       upStb,
  input  logic       upAmo,
  input  logic [3:0] upOp,
  input  logic       upRw,
  input  logic       upLock,
  input  logic       dnAck,
  input  logic       dnErr,
  input  logic       resvHit,
  output logic       dnStb,
  output logic       dnRw,
  output logic       dnLock,
  output logic       upAck,
  output logic       upErr,
  output logic       isIdle,
  output ctl_t       ctl
);

  typedef enum logic [2:0] {
    S_IDLE, S_PASS, S_RD, S_WR, S_WRW, S_SCW, S_SCF
  } state_e;

  state_e state, stateNxt;
  logic   isLr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      isLr  <= 1'b0;
    end else begin
      state <= stateNxt;
      if (state == S_IDLE && upStb) isLr <= (upOp == OP_LR);
    end
  end

  assign isIdle = (state == S_IDLE);

  always_comb begin
    stateNxt    = state;
    dnStb       = 1'b0;
    dnRw        = 1'b0;
    dnLock      = 1'b0;
    upAck       = 1'b0;
    upErr       = 1'b0;
    ctl.capture = 1'b0;
    ctl.loadOld = 1'b0;
    ctl.setResv = 1'b0;
    ctl.clrResv = 1'b0;
    ctl.dnSel   = DN_UP;
    ctl.upSel   = UP_DN;
    unique case (state)
      S_IDLE: if (upStb) begin
        ctl.capture = 1'b1;
        dnStb       = 1'b1;
        if (!upAmo) begin
          dnRw     = upRw;
          dnLock   = upLock;
          stateNxt = S_PASS;
        end else if (upOp == OP_SC) begin
          ctl.clrResv = 1'b1;
          ctl.dnSel   = DN_UPW;
          dnStb       = resvHit;
          dnRw        = 1'b1;
          stateNxt    = resvHit ? S_SCW : S_SCF;
        end else begin
          ctl.dnSel = DN_UPW;
          dnLock    = (upOp != OP_LR);
          stateNxt  = S_RD;
        end
      end
      S_PASS: begin
        upAck = dnAck && !dnErr;
        upErr = dnErr;
        if (dnAck || dnErr) stateNxt = S_IDLE;
      end
      S_RD: begin
        ctl.dnSel = DN_HOLD;
        dnLock    = !isLr;
        if (dnErr) begin
          upErr    = 1'b1;
          stateNxt = S_IDLE;
        end else if (dnAck) begin
          if (isLr) begin
            upAck       = 1'b1;
            ctl.setResv = 1'b1;
            stateNxt    = S_IDLE;
          end else begin
            ctl.loadOld = 1'b1;
            stateNxt    = S_WR;
          end
        end
      end
      S_WR: begin
        ctl.dnSel = DN_NEW;
        dnStb     = 1'b1;
        dnRw      = 1'b1;
        dnLock    = 1'b1;
        stateNxt  = S_WRW;
      end
      S_WRW: begin
        ctl.dnSel = DN_NEW;
        ctl.upSel = UP_OLD;
        dnRw      = 1'b1;
        dnLock    = 1'b1;
        upAck     = dnAck && !dnErr;
        upErr     = dnErr;
        if (dnAck || dnErr) stateNxt = S_IDLE;
      end
      S_SCW: begin
        ctl.dnSel = DN_HOLD;
        ctl.upSel = UP_ZERO;
        dnRw      = 1'b1;
        upAck     = dnAck && !dnErr;
        upErr     = dnErr;
        if (dnAck || dnErr) stateNxt = S_IDLE;
      end
      default: begin
        ctl.upSel = UP_ONE;
        upAck     = 1'b1;
        stateNxt  = S_IDLE;
      end
    endcase
  end

endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   upAddr,
  input  logic [DATA_W-1:0]   upWdata,
  input  logic [DATA_W/8-1:0] upBen,
  input  logic                upStb,
  input  logic                upRw,
  input  logic                upLock,
  input  logic                upAmo,
  input  logic [3:0]          upOp,
  output logic [DATA_W-1:0]   upRdata,
  output logic                upAck,
  output logic                upErr,
  output logic [ADDR_W-1:0]   dnAddr,
  output logic [DATA_W-1:0]   dnWdata,
  output logic [DATA_W/8-1:0] dnBen,
  output logic                dnStb,
  output logic                dnRw,
  output logic                dnLock,
  input  logic [DATA_W-1:0]   dnRdata,
  input  logic                dnAck,
  input  logic                dnErr
);

  ctl_t ctl;
  logic resvHit;
  logic ctlIdle;

  amo_control u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .upStb   (upStb),
    .upAmo   (upAmo),
    .upOp    (upOp),
    .upRw    (upRw),
    .upLock  (upLock),
    .dnAck   (dnAck),
    .dnErr   (dnErr),
    .resvHit (resvHit),
    .dnStb   (dnStb),
    .dnRw    (dnRw),
    .dnLock  (dnLock),
    .upAck   (upAck),
    .upErr   (upErr),
    .isIdle  (ctlIdle),
    .ctl     (ctl)
  );

  amo_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .upAddr  (upAddr),
    .upWdata (upWdata),
    .upBen   (upBen),
    .upOp    (upOp),
    .dnRdata (dnRdata),
    .wrIssue (dnStb && dnRw),
    .dnAddr  (dnAddr),
    .dnWdata (dnWdata),
    .dnBen   (dnBen),
    .upRdata (upRdata),
    .resvHit (resvHit)
  );

endmodule

// File: rtl/amo_unit_checker.sv
module amo_unit_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   upAddr,
  input logic [DATA_W-1:0]   upWdata,
  input logic [DATA_W/8-1:0] upBen,
  input logic                upStb,
  input logic                upRw,
  input logic                upLock,
  input logic                upAmo,
  input logic                upAck,
  input logic                upErr,
  input logic [ADDR_W-1:0]   dnAddr,
  input logic [DATA_W-1:0]   dnWdata,
  input logic [DATA_W/8-1:0] dnBen,
  input logic                dnStb,
  input logic                dnRw,
  input logic                dnLock,
  input logic                ctlIdle
);

  a_r12_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    dnStb |=> !dnStb);

  a_r12_ack_err_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(upAck && upErr));

  a_r2_rmw_write_locked_full: assert property (@(posedge clk) disable iff (!rstN)
    (dnStb && !upStb) |-> (dnRw && dnLock && (&dnBen)));

  a_r1_plain_forward: assert property (@(posedge clk) disable iff (!rstN)
    (ctlIdle && upStb && !upAmo) |-> (dnStb && dnAddr == upAddr && dnWdata == upWdata
      && dnBen == upBen && dnRw == upRw && dnLock == upLock));

  a_r11_busy_no_plain_issue: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlIdle && dnStb) |-> (dnLock && dnRw));

endmodule

bind amo_unit amo_unit_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .upAddr  (upAddr),
  .upWdata (upWdata),
  .upBen   (upBen),
  .upStb   (upStb),
  .upRw    (upRw),
  .upLock  (upLock),
  .upAmo   (upAmo),
  .upAck   (upAck),
  .upErr   (upErr),
  .dnAddr  (dnAddr),
  .dnWdata (dnWdata),
  .dnBen   (dnBen),
  .dnStb   (dnStb),
  .dnRw    (dnRw),
  .dnLock  (dnLock),
  .ctlIdle (ctlIdle)
);

// File: tb/amo_unit_tb.sv
module amo_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] upAddr = '0, upWdata = '0, upRdata;
  logic [3:0]  upBen = '0, upOp = '0;
  logic        upStb = 1'b0, upRw = 1'b0, upLock = 1'b0, upAmo = 1'b0;
  logic        upAck, upErr;
  logic [31:0] dnAddr, dnWdata, dnRdata;
  logic [3:0]  dnBen;
  logic        dnStb, dnRw, dnLock, dnAck, dnErr;

  always #5 clk = ~clk;

  amo_unit u_dut (.*);

  // memory model knobs, driven by the stimulus
  int          lat = 0;
  logic        errRdEn = 1'b0, errWrEn = 1'b0;
  logic [3:0]  errRdIdx = '0, errWrIdx = '0;

  // memory model state
  logic [31:0] mem [16];
  logic        pend, pErr, sErr;
  logic [31:0] pData;
  int          cnt, stbCount, wrCount;
  logic        lastRdLock, lastWrLock;
  logic [3:0]  lastWrBen;

  always @(posedge clk) begin
    dnAck <= 1'b0;
    dnErr <= 1'b0;
    if (!rstN) begin
      pend <= 1'b0; stbCount <= 0; wrCount <= 0; dnRdata <= '0;
      lastRdLock <= 1'b0; lastWrLock <= 1'b0; lastWrBen <= '0;
    end else if (dnStb) begin
      stbCount <= stbCount + 1;
      sErr = dnRw ? (errWrEn && dnAddr[5:2] == errWrIdx) : (errRdEn && dnAddr[5:2] == errRdIdx);
      if (dnRw) begin
        lastWrLock <= dnLock;
        lastWrBen  <= dnBen;
        if (!sErr) begin
          wrCount <= wrCount + 1;
          for (int b = 0; b < 4; b++)
            if (dnBen[b]) mem[dnAddr[5:2]][8*b +: 8] <= dnWdata[8*b +: 8];
        end
      end else begin
        lastRdLock <= dnLock;
      end
      if (lat == 0) begin
        dnAck   <= !sErr;
        dnErr   <= sErr;
        dnRdata <= dnRw ? 32'h0 : mem[dnAddr[5:2]];
      end else begin
        pend  <= 1'b1;
        cnt   <= lat - 1;
        pErr  <= sErr;
        pData <= dnRw ? 32'h0 : mem[dnAddr[5:2]];
      end
    end else if (pend) begin
      if (cnt == 0) begin
        pend    <= 1'b0;
        dnAck   <= !pErr;
        dnErr   <= pErr;
        dnRdata <= pData;
      end else begin
        cnt <= cnt - 1;
      end
    end
  end

  int nChecks = 0, nFail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReq(input logic [31:0] a, input logic [31:0] w, input logic [3:0] be,
                       input logic rw, input logic lk, input logic am, input logic [3:0] op,
                       output logic [31:0] rd, output logic ak, output logic er);
    int n;
    @(negedge clk);
    upAddr = a; upWdata = w; upBen = be; upRw = rw; upLock = lk; upAmo = am; upOp = op;
    upStb = 1'b1;
    @(negedge clk);
    upStb = 1'b0;
    n = 0;
    while (!(upAck || upErr) && n < 200) begin
      @(negedge clk);
      n++;
    end
    rd = upRdata; ak = upAck; er = upErr;
  endtask

  function automatic logic [31:0] refNew(input logic [3:0] op, input logic [31:0] m,
                                         input logic [31:0] o);
    case (op)
      4'b0001:          return m + o;
      4'b0010, 4'b1010: return m ^ o;
      4'b0011, 4'b1011: return m & o;
      4'b0100, 4'b1100: return m | o;
      4'b0110:          return (m < o) ? m : o;
      4'b0111:          return (m > o) ? m : o;
      4'b1110:          return ($signed(m) < $signed(o)) ? m : o;
      4'b1111:          return ($signed(m) > $signed(o)) ? m : o;
      default:          return o;
    endcase
  endfunction

  // {op, initial word, operand}
  localparam logic [67:0] VEC [16] = '{
    {4'b0000, 32'hAAAAAAAA, 32'h12345678},
    {4'b0001, 32'hFFFFFFFF, 32'h00000001},
    {4'b0001, 32'h7FFFFFFF, 32'h00000001},
    {4'b0010, 32'hF0F0F0F0, 32'hFF00FF00},
    {4'b1010, 32'h12345678, 32'hFFFFFFFF},
    {4'b0011, 32'hF0F0F0F0, 32'h3C3C3C3C},
    {4'b1011, 32'hDEADBEEF, 32'h0000FFFF},
    {4'b0100, 32'h0F0F0000, 32'h0000F0F0},
    {4'b1100, 32'h80000000, 32'h00000001},
    {4'b0110, 32'h80000000, 32'h7FFFFFFF},
    {4'b0111, 32'h80000000, 32'h7FFFFFFF},
    {4'b1110, 32'h80000000, 32'h7FFFFFFF},
    {4'b1111, 32'h80000000, 32'h7FFFFFFF},
    {4'b1110, 32'hFFFFFFFF, 32'h00000000},
    {4'b0111, 32'h00000005, 32'h00000005},
    {4'b0101, 32'h11111111, 32'h22222222}
  };

  task automatic finish();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual hung expected done");
    finish();
  end

  initial begin
    logic [31:0] rd;
    logic        ak, er;
    int          s0, w0;

    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13 dnStb", {31'b0, dnStb}, 32'h0);
    chk("R13 upAck", {31'b0, upAck}, 32'h0);
    chk("R13 upErr", {31'b0, upErr}, 32'h0);
    rstN = 1'b1;
    doReq(32'h40, 32'h55, 4'hF, 1'b1, 1'b0, 1'b1, 4'b1001, rd, ak, er);
    chk("R13 sc after reset fails", rd, 32'h1);

    // R1 plain traffic, operation code ignored
    doReq(32'h0C, 32'h11223344, 4'hF, 1'b1, 1'b0, 1'b0, 4'b0001, rd, ak, er);
    chk("R1 write ack", {31'b0, ak}, 32'h1);
    doReq(32'h0C, 32'hAABBCCDD, 4'b0011, 1'b1, 1'b1, 1'b0, 4'b1001, rd, ak, er);
    chk("R1 lock forwarded", {31'b0, lastWrLock}, 32'h1);
    chk("R1 ben forwarded", {28'b0, lastWrBen}, 32'h3);
    doReq(32'h0C, 32'h0, 4'hF, 1'b0, 1'b1, 1'b0, 4'b0000, rd, ak, er);
    chk("R1 partial write readback", rd, 32'h1122CCDD);
    chk("R1 read lock forwarded", {31'b0, lastRdLock}, 32'h1);

    // R2 R3 R4 every operation code, varying latency
    for (int i = 0; i < 16; i++) begin
      lat = i % 3;
      doReq(32'h08, VEC[i][63:32], 4'hF, 1'b1, 1'b0, 1'b0, 4'h0, rd, ak, er);
      doReq(32'h08, VEC[i][31:0], 4'hF, 1'b0, 1'b0, 1'b1, VEC[i][67:64], rd, ak, er);
      chk("R2 old value returned", rd, VEC[i][63:32]);
      chk("R2 locks", {30'b0, lastRdLock, lastWrLock}, 32'h3);
      chk("R2 full ben", {28'b0, lastWrBen}, 32'hF);
      doReq(32'h08, 32'h0, 4'hF, 1'b0, 1'b0, 1'b0, 4'h0, rd, ak, er);
      chk((VEC[i][66:65] == 2'b11) ? "R4 new value" : "R3 new value", rd,
          refNew(VEC[i][67:64], VEC[i][63:32], VEC[i][31:0]));
    end
    lat = 0;

    // R5 read error
    doReq(32'h14, 32'h00000077, 4'hF, 1'b1, 1'b0, 1'b0, 4'h0, rd, ak, er);
    errRdEn = 1'b1; errRdIdx = 4'd5;
    w0 = wrCount;
    doReq(32'h14, 32'h1, 4'hF, 1'b0, 1'b0, 1'b1, 4'b0001, rd, ak, er);
    chk("R5 error returned", {30'b0, ak, er}, 32'h1);
    chk("R5 no write", wrCount, w0);
    errRdEn = 1'b0;
    doReq(32'h14, 32'h0, 4'hF, 1'b0, 1'b0, 1'b0, 4'h0, rd, ak, er);
    chk("R5 word unchanged", rd, 32'h77);

    // R6 write error
    errWrEn = 1'b1; errWrIdx = 4'd5;
    doReq(32'h14, 32'h9, 4'hF, 1'b0, 1'b0, 1'b1, 4'b0000, rd, ak, er);
    chk("R6 error returned", {30'b0, ak, er}, 32'h1);
    errWrEn = 1'b0;

    // R7 R8 load-reserved then store-conditional
    doReq(32'h20, 32'hCAFE0001, 4'hF, 1'b1, 1'b0, 1'b0, 4'h0, rd, ak, er);
    doReq(32'h22, 32'h0, 4'hF, 1'b0, 1'b0, 1'b1, 4'b1000, rd, ak, er);
    chk("R7 lr data", rd, 32'hCAFE0001);
    chk("R7 lr unlocked", {31'b0, lastRdLock}, 32'h0);
    doReq(32'h20, 32'h0BEEF000, 4'hF, 1'b0, 1'b0, 1'b1, 4'b1001, rd, ak, er);
    chk("R8 sc success code", rd, 32'h0);
    chk("R8 sc unlocked full", {27'b0, lastWrLock, lastWrBen}, 32'hF);
    doReq(32'h20, 32'h0, 4'hF, 1'b0, 1'b0, 1'b0, 4'h0, rd, ak, er);
    chk("R8 sc stored", rd, 32'h0BEEF000);

    // R9 second sc fails without bus access
    s0 = stbCount;
    doReq(32'h20, 32'h12121212, 4'hF, 1'b0, 1'b0, 1'b1, 4'b1001, rd, ak, er);
    chk("R9 sc fail code", rd, 32'h1);
    chk("R9 no bus access", stbCount, s0);
    doReq(32'h20, 32'h0, 4'hF, 1'b0, 1'b0, 1'b1, 4'b1000, rd, ak, er);
    doReq(32'h24, 32'h5, 4'hF, 1'b0, 1'b0, 1'b1, 4'b1001, rd, ak, er);
    chk("R9 other word fails", rd, 32'h1);
    doReq(32'h20, 32'h5, 4'hF, 1'b0, 1'b0, 1'b1, 4'b1001, rd, ak, er);
    chk("R9 reservation cleared by sc", rd, 32'h1);

    // R10 writes to the reserved word clear it, others do not
    doReq(32'h20, 32'h0, 4'hF, 1'b0, 1'b0, 1'b1, 4'b1000, rd, ak, er);
    doReq(32'h23, 32'hFF000000, 4'b1000, 1'b1, 1'b0, 1'b0, 4'h0, rd, ak, er);
    doReq(32'h20, 32'h6, 4'hF, 1'b0, 1'b0, 1'b1, 4'b1001, rd, ak, er);
    chk("R10 partial write clears", rd, 32'h1);
    doReq(32'h20, 32'h0, 4'hF, 1'b0, 1'b0, 1'b1, 4'b1000, rd, ak, er);
    doReq(32'h30, 32'h1, 4'hF, 1'b1, 1'b0, 1'b0, 4'h0, rd, ak, er);
    doReq(32'h20, 32'h7, 4'hF, 1'b0, 1'b0, 1'b1, 4'b1001, rd, ak, er);
    chk("R10 other write keeps", rd, 32'h0);

    // R11 strobe during an atomic operation is dropped
    doReq(32'h24, 32'h00000033, 4'hF, 1'b1, 1'b0, 1'b0, 4'h0, rd, ak, er);
    lat = 4;
    s0 = stbCount;
    @(negedge clk);
    upAddr = 32'h08; upWdata = 32'h2; upBen = 4'hF; upRw = 1'b0; upAmo = 1'b1; upOp = 4'b0001;
    upStb = 1'b1;
    @(negedge clk);
    upStb = 1'b0;
    @(negedge clk);
    upAddr = 32'h24; upWdata = 32'hDEAD0000; upRw = 1'b1; upAmo = 1'b0; upStb = 1'b1;
    @(negedge clk);
    upStb = 1'b0;
    for (int n = 0; n < 40 && !(upAck || upErr); n++) @(negedge clk);
    repeat (8) @(negedge clk);
    chk("R11 two bus accesses", stbCount - s0, 32'd2);
    lat = 0;
    doReq(32'h24, 32'h0, 4'hF, 1'b0, 1'b0, 1'b0, 4'h0, rd, ak, er);
    chk("R11 dropped write no effect", rd, 32'h33);

    // R12 long latency response
    lat = 7;
    doReq(32'h24, 32'h0, 4'hF, 1'b0, 1'b0, 1'b1, 4'b0100, rd, ak, er);
    chk("R12 slow ack", {30'b0, ak, er}, 32'h2);
    chk("R12 slow data", rd, 32'h33);
    lat = 0;

    finish();
  end

endmodule